// File: doc/BRIEF.md
# LDPC Decoder Iteration Controller

This block sequences the iterations of a small soft-decision LDPC decoder whose parity-check matrix has 8 rows and 12 columns. The arithmetic (loading the channel priors into the edge memory, the check-node update, the variable-node update and the posterior estimation) lives in external datapaths. The controller reaches each of them through a one-cycle go pulse, and the datapath answers with a one-cycle done strobe.

After a start pulse the controller runs the load step once. It then loops through check-node update, variable-node update and estimation. When estimation finishes, the controller captures the 12-bit hard-decision word and forms its 8-bit syndrome. For each row of the matrix it ANDs the word with that row and XOR-reduces the result. An all-zero syndrome ends decoding with success. A nonzero syndrome starts another iteration, until a preset limit on the iteration count is reached. On a stop the controller reports the decision word, its syndrome, the number of iterations used and a success flag. These outputs hold until the next decode finishes.

The matrix is a 96-bit parameter. Bit `r*12 + c` is the entry in row r, column c, and column c multiplies decision bit c.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: Syndrome bit r equals the XOR over c of (decision bit c AND matrix bit r*12+c). The matrix bit index is r*12+c, with r in 0..7 and c in 0..11.
- R2: After start the go pulses appear in this order: load (`init_go`) once, then `hstep_go`, `vstep_go`, `est_go` repeating for each iteration. At most one go is high in any cycle.
- R3: Each go pulse is issued only after the done strobe of the previous step. A done strobe received while the controller is idle produces no go pulse and leaves `busy` low.
- R4: When the captured decision word has an all-zero syndrome, decoding stops with `success`=1, `syndrome`=0, `dec_word` equal to that word and `iter_used` equal to the number of syndrome checks performed (1 for the first).
- R5: When MAX_ITER iterations have all produced a nonzero syndrome, decoding stops with `success`=0, `iter_used`=MAX_ITER, and `dec_word` and `syndrome` taken from the last iteration.
- R6: `fin` is high for exactly one cycle, the cycle in which the results first appear. `dec_word`, `syndrome`, `iter_used` and `success` then hold until the next decode finishes.
- R7: A start pulse while `busy` is high is ignored: no second load step, and the running decode's results are unchanged.
- R8: After reset, all go outputs, `busy`, `fin`, `dec_word`, `syndrome`, `iter_used` and `success` are 0.
- R9: The iteration counter is 8 bits wide and never exceeds MAX_ITER (default 20). The elaboration rejects a MAX_ITER below 1 or above 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode (ignored while busy) |
| init_done | input | 1 | Load datapath finished |
| hstep_done | input | 1 | Check-node datapath finished |
| vstep_done | input | 1 | Variable-node datapath finished |
| est_done | input | 1 | Estimation datapath finished, `est_word` valid |
| est_word | input | 12 | Hard-decision word from estimation |
| init_go | output | 1 | Pulse: run load step |
| hstep_go | output | 1 | Pulse: run check-node step |
| vstep_go | output | 1 | Pulse: run variable-node step |
| est_go | output | 1 | Pulse: run estimation step |
| busy | output | 1 | Decode in progress |
| fin | output | 1 | One-cycle pulse: results valid |
| dec_word | output | 12 | Final decision word |
| syndrome | output | 8 | Syndrome of `dec_word` |
| iter_used | output | 8 | Iterations performed |
| success | output | 1 | Syndrome was zero at stop |

## Verification
The hardest situations to reach are two boundary cases. One is a codeword that first appears exactly at the last permitted iteration, which must still end with success. The other is a limit run in which every one of the MAX_ITER words fails, which must end with the flag cleared. The bench plays the external datapaths: it answers each go pulse after a random delay and feeds scripted decision words. Each script plants a codeword at a chosen iteration and fills the earlier slots with random words filtered to have nonzero syndromes. The directed scripts place the codeword at iteration 1, 7 and MAX_ITER, and one script contains none at all.

// File: rtl/ldpc_ctrl_pkg.sv
package ldpc_ctrl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INIT,
      ST_HSTEP,
      ST_VSTEP,
      ST_EST,
      ST_SYN,
      ST_DONE
   } ctrl_state_t;
endpackage

// File: rtl/ldpc_syn_calc.sv
module ldpc_syn_calc #(
   parameter int ROWS = 8,
   parameter int COLS = 12,
   parameter logic [ROWS*COLS-1:0] H_MAT = '0
) (
   input  logic [COLS-1:0] word_i,
   output logic [ROWS-1:0] syn_o
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign syn_o[r] = ^(word_i & H_MAT[r*COLS +: COLS]);
   end

   // R1: the zero word can never violate a parity row
   always_comb begin
      if (word_i == '0) begin
         zero_word_syn_chk: assert (syn_o == '0);
      end
   end
endmodule

// File: rtl/ldpc_iter_fsm.sv
module ldpc_iter_fsm
   import ldpc_ctrl_pkg::*;
#(
   parameter int ROWS     = 8,
   parameter int COLS     = 12,
   parameter int MAX_ITER = 20,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             init_done,
   input  logic             h_done,
   input  logic             v_done,
   input  logic             e_done,
   input  logic [COLS-1:0]  est_word,
   input  logic [ROWS-1:0]  syn_in,
   output logic [COLS-1:0]  hd_o,
   output logic             init_go,
   output logic             h_go,
   output logic             v_go,
   output logic             e_go,
   output logic             busy,
   output logic             fin,
   output logic [COLS-1:0]  word_o,
   output logic [ROWS-1:0]  syn_o,
   output logic [CNT_W-1:0] iters_o,
   output logic             ok_o
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ITER);

   if (MAX_ITER < 1 || MAX_ITER >= (1 << CNT_W)) begin : g_bad_limit
      $error("ldpc_iter_fsm: MAX_ITER out of range for CNT_W");
   end

   ctrl_state_t      state;
   logic [CNT_W-1:0] iter_q;
   logic [CNT_W-1:0] iter_nxt;
   logic [COLS-1:0]  hd_q;
   logic             syn_zero;

   assign iter_nxt = iter_q + 1'b1;
   assign syn_zero = (syn_in == '0);
   assign hd_o     = hd_q;
   assign busy     = (state != ST_IDLE);
   assign fin      = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         iter_q  <= '0;
         hd_q    <= '0;
         init_go <= 1'b0;
         h_go    <= 1'b0;
         v_go    <= 1'b0;
         e_go    <= 1'b0;
         word_o  <= '0;
         syn_o   <= '0;
         iters_o <= '0;
         ok_o    <= 1'b0;
      end else begin
         init_go <= 1'b0;
         h_go    <= 1'b0;
         v_go    <= 1'b0;
         e_go    <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state   <= ST_INIT;
               init_go <= 1'b1;
               iter_q  <= '0;
            end
            ST_INIT: if (init_done) begin
               state <= ST_HSTEP;
               h_go  <= 1'b1;
            end
            ST_HSTEP: if (h_done) begin
               state <= ST_VSTEP;
               v_go  <= 1'b1;
            end
            ST_VSTEP: if (v_done) begin
               state <= ST_EST;
               e_go  <= 1'b1;
            end
            ST_EST: if (e_done) begin
               state <= ST_SYN;
               hd_q  <= est_word;
            end
            ST_SYN: begin
               iter_q <= iter_nxt;
               if (syn_zero || iter_nxt == LIMIT) begin
                  state   <= ST_DONE;
                  word_o  <= hd_q;
                  syn_o   <= syn_in;
                  iters_o <= iter_nxt;
                  ok_o    <= syn_zero;
               end else begin
                  state <= ST_HSTEP;
                  h_go  <= 1'b1;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({init_go, h_go, v_go, e_go}));

   // R9
   iter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iter_q <= LIMIT);

   // R4
   ok_zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && ok_o) |-> (syn_o == '0));

   // R5
   fail_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !ok_o) |-> (iters_o == LIMIT && syn_o != '0));

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fin || ($stable(word_o) && $stable(ok_o) && $stable(iters_o))));

   // R7
   start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !init_go);
endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl #(
   parameter int ROWS     = 8,
   parameter int COLS     = 12,
   parameter int MAX_ITER = 20,
   parameter int CNT_W    = 8,
   parameter logic [ROWS*COLS-1:0] H_MAT = 96'h920484212049E001C0038007
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             init_done,
   input  logic             hstep_done,
   input  logic             vstep_done,
   input  logic             est_done,
   input  logic [COLS-1:0]  est_word,
   output logic             init_go,
   output logic             hstep_go,
   output logic             vstep_go,
   output logic             est_go,
   output logic             busy,
   output logic             fin,
   output logic [COLS-1:0]  dec_word,
   output logic [ROWS-1:0]  syndrome,
   output logic [CNT_W-1:0] iter_used,
   output logic             success
);
   if (ROWS < 1 || COLS < 1) begin : g_bad_shape
      $error("ldpc_iter_ctrl: matrix dimensions must be positive");
   end

   logic [COLS-1:0] hd_w;
   logic [ROWS-1:0] syn_w;

   ldpc_syn_calc #(
      .ROWS (ROWS),
      .COLS (COLS),
      .H_MAT(H_MAT)
   ) u_syn (
      .word_i(hd_w),
      .syn_o (syn_w)
   );

   ldpc_iter_fsm #(
      .ROWS    (ROWS),
      .COLS    (COLS),
      .MAX_ITER(MAX_ITER),
      .CNT_W   (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .init_done(init_done),
      .h_done   (hstep_done),
      .v_done   (vstep_done),
      .e_done   (est_done),
      .est_word (est_word),
      .syn_in   (syn_w),
      .hd_o     (hd_w),
      .init_go  (init_go),
      .h_go     (hstep_go),
      .v_go     (vstep_go),
      .e_go     (est_go),
      .busy     (busy),
      .fin      (fin),
      .word_o   (dec_word),
      .syn_o    (syndrome),
      .iters_o  (iter_used),
      .ok_o     (success)
   );
endmodule

// File: tb/ldpc_iter_ctrl_bench.sv
module ldpc_iter_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAXI = 20;
   localparam logic [11:0] RW0 = 12'h007, RW1 = 12'h038, RW2 = 12'h1C0, RW3 = 12'hE00;
   localparam logic [11:0] RW4 = 12'h049, RW5 = 12'h212, RW6 = 12'h484, RW7 = 12'h920;
   localparam logic [95:0] HB = {RW7, RW6, RW5, RW4, RW3, RW2, RW1, RW0};

   logic clk = 0, rst_n = 0, start = 0;
   logic init_done = 0, hstep_done = 0, vstep_done = 0, est_done = 0;
   logic [11:0] est_word = '0;
   logic init_go, hstep_go, vstep_go, est_go, busy, fin, success;
   logic [11:0] dec_word;
   logic [7:0]  syndrome, iter_used;

   int n_chk = 0, n_fail = 0, order_err = 0, exp_step = 0, word_idx = 0;
   logic [11:0] words [0:63];
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldpc_iter_ctrl #(.MAX_ITER(MAXI), .H_MAT(HB)) u_ldpc_iter_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .init_done(init_done), .hstep_done(hstep_done), .vstep_done(vstep_done),
      .est_done(est_done), .est_word(est_word),
      .init_go(init_go), .hstep_go(hstep_go), .vstep_go(vstep_go), .est_go(est_go),
      .busy(busy), .fin(fin), .dec_word(dec_word), .syndrome(syndrome),
      .iter_used(iter_used), .success(success));

   function automatic logic [7:0] syn_f(logic [11:0] w);
      logic [11:0] rows [8];
      logic [7:0] s;
      rows = '{RW0, RW1, RW2, RW3, RW4, RW5, RW6, RW7};
      for (int r = 0; r < 8; r++) s[r] = ^(w & rows[r]);
      return s;
   endfunction

   function automatic logic [11:0] noisy_word();
      logic [11:0] w;
      w = 12'($urandom);
      while (syn_f(w) == 8'h00) w = 12'($urandom);
      return w;
   endfunction

   function automatic logic [11:0] code_word();
      logic [11:0] w;
      w = 12'($urandom);
      while (syn_f(w) != 8'h00) w = 12'($urandom);
      return w;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // datapath model: answers each go after a random delay
   initial begin
      @(posedge clk); #1;
      forever begin
         if (init_go | hstep_go | vstep_go | est_go) begin
            logic [3:0] exp_v, got_v;
            got_v = {est_go, vstep_go, hstep_go, init_go};
            exp_v = 4'b0001 << exp_step;
            if (got_v != exp_v) order_err++;
            exp_step = (exp_step == 3) ? 1 : exp_step + 1;
            repeat ($urandom % 3) @(posedge clk);
            #0;
            if (got_v[0]) init_done = 1;
            if (got_v[1]) hstep_done = 1;
            if (got_v[2]) vstep_done = 1;
            if (got_v[3]) begin
               est_done = 1;
               est_word = words[word_idx];
               word_idx++;
            end
            @(posedge clk); #1;
            {init_done, hstep_done, vstep_done, est_done} = '0;
         end else begin
            @(posedge clk); #1;
         end
      end
   end

   task automatic run_decode(bit poke_start);
      int k, c;
      logic [11:0] ew;
      k = MAXI;
      for (int i = 0; i < MAXI; i++) if (syn_f(words[i]) == 8'h00) begin k = i + 1; break; end
      ew = words[k-1];
      order_err = 0; exp_step = 0; word_idx = 0;
      @(posedge clk); #1 start = 1;
      @(posedge clk); #1 start = 0;
      c = 0;
      while (!fin && c < 3000) begin
         @(posedge clk); #1; c++;
         if (poke_start && c == 4) start = 1;
         if (poke_start && c == 5) start = 0;
      end
      start = 0;
      chk("R6 fin reached", 32'(fin), 1);
      chk("R4/R5 dec_word", 32'(dec_word), 32'(ew));
      chk("R1 syndrome", 32'(syndrome), 32'(syn_f(ew)));
      chk("R9 iter_used", 32'(iter_used), 32'(k));
      chk("R4/R5 success", 32'(success), 32'(syn_f(ew) == 8'h00));
      chk("R2/R3/R7 step order", 32'(order_err), 0);
      @(posedge clk); #1;
      chk("R6 fin one cycle", 32'(fin), 0);
      repeat (3) @(posedge clk); #1;
      chk("R6 result held", 32'(dec_word), 32'(ew));
      chk("R6 idle after stop", 32'(busy), 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 64; i++) words[i] = '0;
      repeat (3) @(posedge clk); #1;
      chk("R8 reset go", 32'({init_go, hstep_go, vstep_go, est_go}), 0);
      chk("R8 reset busy/fin", 32'({busy, fin, success}), 0);
      chk("R8 reset results", 32'({dec_word, syndrome, iter_used}), 0);
      rst_n = 1;
      repeat (2) @(posedge clk); #1;
      // R3: done strobes while idle
      {init_done, hstep_done, vstep_done, est_done} = 4'hF;
      repeat (3) @(posedge clk); #1;
      chk("R3 no go when idle", 32'({init_go, hstep_go, vstep_go, est_go, busy}), 0);
      {init_done, hstep_done, vstep_done, est_done} = '0;
      @(posedge clk); #1;
      chk("R3 idle go/busy", 32'({init_go, hstep_go, vstep_go, est_go, busy}), 0);
      // R4 success at first iteration
      words[0] = code_word();
      run_decode(0);
      // R4 success at iteration 7
      for (int i = 0; i < 6; i++) words[i] = noisy_word();
      words[6] = code_word();
      run_decode(0);
      // R5 no codeword within limit
      for (int i = 0; i < MAXI; i++) words[i] = noisy_word();
      run_decode(0);
      // R4 codeword exactly at last permitted iteration
      words[MAXI-1] = code_word();
      run_decode(0);
      // R7 start while busy
      for (int i = 0; i < 2; i++) words[i] = noisy_word();
      words[2] = code_word();
      run_decode(1);
      // random scripts
      for (int t = 0; t < 8; t++) begin
         int k;
         k = 1 + ($urandom % (MAXI + 3));
         for (int i = 0; i < MAXI; i++) words[i] = noisy_word();
         if (k <= MAXI) words[k-1] = code_word();
         run_decode(0);
      end
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule